// File: doc/BRIEF.md
# Clustered Register Rename with On-Demand Copies

This block is the rename stage of a back-end split into four execution clusters. Each cluster has its own physical register file. One logical register may have live copies in several of these files at once. For each logical register, a location map records which clusters hold its current value and at which physical index. Each instruction arrives with two logical sources, a logical destination and the cluster that steering picked. The block returns physical tags that are valid inside that cluster.

A source may have no copy in the target cluster. In that case the block allocates a register there and emits a copy operation that moves the value from a cluster that holds it. From then on the map lists the target cluster as a holder. The destination gets a fresh register in the target cluster. All earlier locations of that logical register are dropped from the map. They are handed out with the result, so that commit can later return them to the free lists.

Rename input and result output are valid/ready streams. Rules for back-pressure:
- An instruction is taken on a cycle where `in_valid` and `in_ready` are both high.
- `in_ready` stays low while a result is held and `out_ready` is low.
- `in_ready` also stays low while the target cluster cannot supply every register the instruction needs. This check depends on the input fields, so the input must keep its fields stable while `in_valid` is high.
- A result, with its copy requests, stays on the output until `out_ready` is high.

Commit is a plain pulse with no back-pressure.

Top module: `crn_rename`

## Requirements
- R1: After reset the output holds no result. Logical register i is held only by cluster 0, at index i. Cluster 0 has indices 16..31 free, and clusters 1 to 3 have all 32 free.
- R2: A tag is the cluster number in bits 6:5 and the index in bits 4:0. The destination tag names the target cluster and the lowest free index in that cluster.
- R3: A source that is already held by the target cluster gets the target cluster's index from the map. No copy is made for it.
- R4: A source not held by the target cluster gets a new register in the target cluster. A copy is requested from the lowest-numbered cluster holding it. Source 0's copy is on the copy-0 port, and its source tag equals the copy's destination tag. Allocation order is: destination, then source 0's copy, then source 1's copy, each taking the lowest remaining free index.
- R5: When both sources name the same remote logical register, only one copy is made, on copy 0. Both source tags name that one register.
- R6: The result carries the previous mapping of the destination: a 4-bit mask of the clusters that held it (bit c for cluster c) and a 5-bit index per cluster at bits 5c+4:5c. A copy made by the same instruction for a source equal to the destination counts as part of it.
- R7: A commit pulse returns every index named in its mask to that cluster's free list. A returned index can be allocated again from the next cycle.
- R8: `in_ready` is low when the target cluster has fewer free registers than the destination plus the copies needed. No state changes for a refused instruction.
- R9: While `out_valid` is high and `out_ready` is low, the result stays unchanged and `in_ready` is low.
- R10: When the two sources are remote and distinct, two copies are issued in the same result. Their source clusters may differ, and all three new registers are distinct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| in_valid | input | 1 | instruction offered |
| in_ready | output | 1 | instruction can be taken |
| in_cluster | input | 2 | target cluster from steering |
| in_src0 | input | 4 | logical source 0 |
| in_src1 | input | 4 | logical source 1 |
| in_dst | input | 4 | logical destination |
| out_valid | output | 1 | result held |
| out_ready | input | 1 | consumer takes result |
| out_src0_tag | output | 7 | physical tag of source 0 |
| out_src1_tag | output | 7 | physical tag of source 1 |
| out_dst_tag | output | 7 | physical tag of destination |
| out_old_mask | output | 4 | clusters of the previous mapping |
| out_old_idx | output | 20 | previous indices, 5 bits per cluster |
| out_cp0_valid | output | 1 | copy for source 0 requested |
| out_cp0_from | output | 7 | tag read by copy 0 |
| out_cp0_to | output | 7 | tag written by copy 0 |
| out_cp1_valid | output | 1 | copy for source 1 requested |
| out_cp1_from | output | 7 | tag read by copy 1 |
| out_cp1_to | output | 7 | tag written by copy 1 |
| commit_valid | input | 1 | release pulse |
| commit_mask | input | 4 | clusters whose index is released |
| commit_idx | input | 20 | indices released, 5 bits per cluster |

## Verification
The bench targets four kinds of corner case:
- **Identical remote sources.** A design that forgot to share the copy would emit two copies and use up an extra register.
- **A source equal to the destination.** A design that read the map before the copy was recorded would omit that copy from the old mask, and that register would never be freed.
- **Running a cluster dry.** With commits held back, the bench drains a cluster until an instruction needing three registers is refused while one needing a single register would fit. A wrong free count either over-allocates a busy index or stalls forever.
- **Release and allocation in the same cycle.** This is what exposes an allocator that grabs a register being released, or loses a release.

// File: rtl/crn_pkg.sv
package crn_pkg;
  localparam int unsigned NUM_CLUSTERS     = 4;
  localparam int unsigned NUM_LOGICAL      = 16;
  localparam int unsigned PHYS_PER_CLUSTER = 32;
  localparam int unsigned ALLOC_SLOTS      = 3;
  localparam int unsigned CLW  = $clog2(NUM_CLUSTERS);
  localparam int unsigned IDXW = $clog2(PHYS_PER_CLUSTER);
  localparam int unsigned LOGW = $clog2(NUM_LOGICAL);
  localparam int unsigned TAGW = CLW + IDXW;
  localparam int unsigned CNTW = $clog2(PHYS_PER_CLUSTER + 1);

  typedef logic [CLW-1:0]  cl_t;
  typedef logic [IDXW-1:0] idx_t;
  typedef logic [LOGW-1:0] log_t;
  typedef logic [TAGW-1:0] tag_t;
endpackage

// File: rtl/crn_free_list.sv
module crn_free_list import crn_pkg::*; #(
  parameter int unsigned INIT_BUSY = 0
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [ALLOC_SLOTS-1:0]              take,
  input  logic                                rel_en,
  input  logic [IDXW-1:0]                     rel_idx,
  output logic [ALLOC_SLOTS-1:0][IDXW-1:0]    pick,
  output logic [CNTW-1:0]                     avail
);
  logic [PHYS_PER_CLUSTER-1:0] free_q;
  logic [PHYS_PER_CLUSTER-1:0] grab;
  logic [PHYS_PER_CLUSTER-1:0] back;

  // lowest free indices in ascending order, one per slot
  always_comb begin
    logic [PHYS_PER_CLUSTER-1:0] rest;
    logic hit;
    rest = free_q;
    pick = '0;
    for (int k = 0; k < ALLOC_SLOTS; k++) begin
      hit = 1'b0;
      for (int i = 0; i < PHYS_PER_CLUSTER; i++) begin
        if (!hit && rest[i]) begin
          pick[k] = IDXW'(i);
          hit     = 1'b1;
          rest[i] = 1'b0;
        end
      end
    end
  end

  always_comb begin
    grab = '0;
    for (int k = 0; k < ALLOC_SLOTS; k++)
      if (take[k]) grab[pick[k]] = 1'b1;
    back = '0;
    if (rel_en) back[rel_idx] = 1'b1;
  end

  assign avail = CNTW'($countones(free_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PHYS_PER_CLUSTER; i++)
        free_q[i] <= (i >= INIT_BUSY);
    end else begin
      free_q <= (free_q & ~grab) | back;
    end
  end
endmodule

// File: rtl/crn_map_table.sv
module crn_map_table import crn_pkg::*; (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [LOGW-1:0]                        rd_a,
  input  logic [LOGW-1:0]                        rd_b,
  input  logic [LOGW-1:0]                        rd_d,
  output logic [NUM_CLUSTERS-1:0]                a_pres,
  output logic [NUM_CLUSTERS-1:0][IDXW-1:0]      a_idx,
  output logic [NUM_CLUSTERS-1:0]                b_pres,
  output logic [NUM_CLUSTERS-1:0][IDXW-1:0]      b_idx,
  output logic [NUM_CLUSTERS-1:0]                d_pres,
  output logic [NUM_CLUSTERS-1:0][IDXW-1:0]      d_idx,
  input  logic                                   wr_en,
  input  logic [CLW-1:0]                         wr_cl,
  input  logic                                   cp0_en,
  input  logic [LOGW-1:0]                        cp0_log,
  input  logic [IDXW-1:0]                        cp0_idx,
  input  logic                                   cp1_en,
  input  logic [LOGW-1:0]                        cp1_log,
  input  logic [IDXW-1:0]                        cp1_idx,
  input  logic [IDXW-1:0]                        dst_idx
);
  logic [NUM_LOGICAL-1:0][NUM_CLUSTERS-1:0]            pres_q;
  logic [NUM_LOGICAL-1:0][NUM_CLUSTERS-1:0][IDXW-1:0]  idx_q;

  assign a_pres = pres_q[rd_a];
  assign a_idx  = idx_q[rd_a];
  assign b_pres = pres_q[rd_b];
  assign b_idx  = idx_q[rd_b];
  assign d_pres = pres_q[rd_d];
  assign d_idx  = idx_q[rd_d];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < NUM_LOGICAL; l++) begin
        pres_q[l] <= NUM_CLUSTERS'(1);
        for (int c = 0; c < NUM_CLUSTERS; c++)
          idx_q[l][c] <= (c == 0) ? IDXW'(l) : '0;
      end
    end else if (wr_en) begin
      if (cp0_en) begin
        pres_q[cp0_log][wr_cl] <= 1'b1;
        idx_q[cp0_log][wr_cl]  <= cp0_idx;
      end
      if (cp1_en) begin
        pres_q[cp1_log][wr_cl] <= 1'b1;
        idx_q[cp1_log][wr_cl]  <= cp1_idx;
      end
      // destination write comes last so it overrides a copy to the same row
      pres_q[rd_d]        <= NUM_CLUSTERS'(1) << wr_cl;
      idx_q[rd_d][wr_cl]  <= dst_idx;
    end
  end
endmodule

// File: rtl/crn_rename.sv
module crn_rename import crn_pkg::*; (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [CLW-1:0]                in_cluster,
  input  logic [LOGW-1:0]               in_src0,
  input  logic [LOGW-1:0]               in_src1,
  input  logic [LOGW-1:0]               in_dst,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [TAGW-1:0]               out_src0_tag,
  output logic [TAGW-1:0]               out_src1_tag,
  output logic [TAGW-1:0]               out_dst_tag,
  output logic [NUM_CLUSTERS-1:0]       out_old_mask,
  output logic [NUM_CLUSTERS*IDXW-1:0]  out_old_idx,
  output logic                          out_cp0_valid,
  output logic [TAGW-1:0]               out_cp0_from,
  output logic [TAGW-1:0]               out_cp0_to,
  output logic                          out_cp1_valid,
  output logic [TAGW-1:0]               out_cp1_from,
  output logic [TAGW-1:0]               out_cp1_to,
  input  logic                          commit_valid,
  input  logic [NUM_CLUSTERS-1:0]       commit_mask,
  input  logic [NUM_CLUSTERS*IDXW-1:0]  commit_idx
);
  function automatic cl_t first_holder(input logic [NUM_CLUSTERS-1:0] p);
    cl_t r;
    r = '0;
    for (int c = NUM_CLUSTERS - 1; c >= 0; c--)
      if (p[c]) r = cl_t'(c);
    return r;
  endfunction

  logic [NUM_CLUSTERS-1:0]                 a_pres, b_pres, d_pres;
  logic [NUM_CLUSTERS-1:0][IDXW-1:0]       a_idx, b_idx, d_idx;
  logic [NUM_CLUSTERS-1:0][ALLOC_SLOTS-1:0][IDXW-1:0] fl_pick;
  logic [NUM_CLUSTERS-1:0][CNTW-1:0]       fl_avail;
  logic [NUM_CLUSTERS-1:0][ALLOC_SLOTS-1:0] fl_take;

  logic [ALLOC_SLOTS-1:0][IDXW-1:0] t_pick;
  logic [ALLOC_SLOTS-1:0]           take_vec;
  logic                             need0, need1, room, accept;
  logic [CNTW-1:0]                  n_need;
  idx_t                             cp0_idx, cp1_idx, dst_idx;
  cl_t                              h0, h1;
  logic [NUM_CLUSTERS-1:0]          tgt_bit, old_mask;
  logic [NUM_CLUSTERS*IDXW-1:0]     old_idx;
  tag_t                             s0_tag, s1_tag;

  crn_map_table u_map (
    .clk(clk), .rst_n(rst_n),
    .rd_a(in_src0), .rd_b(in_src1), .rd_d(in_dst),
    .a_pres(a_pres), .a_idx(a_idx),
    .b_pres(b_pres), .b_idx(b_idx),
    .d_pres(d_pres), .d_idx(d_idx),
    .wr_en(accept), .wr_cl(in_cluster),
    .cp0_en(need0), .cp0_log(in_src0), .cp0_idx(cp0_idx),
    .cp1_en(need1), .cp1_log(in_src1), .cp1_idx(cp1_idx),
    .dst_idx(dst_idx)
  );

  for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : g_fl
    localparam int unsigned BUSY = (c == 0) ? NUM_LOGICAL : 0;
    assign fl_take[c] = (accept && in_cluster == cl_t'(c)) ? take_vec : '0;
    crn_free_list #(.INIT_BUSY(BUSY)) u_fl (
      .clk(clk), .rst_n(rst_n),
      .take(fl_take[c]),
      .rel_en(commit_valid && commit_mask[c]),
      .rel_idx(commit_idx[c*IDXW +: IDXW]),
      .pick(fl_pick[c]),
      .avail(fl_avail[c])
    );
  end

  always_comb begin
    t_pick   = fl_pick[in_cluster];
    tgt_bit  = NUM_CLUSTERS'(1) << in_cluster;
    need0    = !a_pres[in_cluster];
    need1    = !b_pres[in_cluster] && (in_src1 != in_src0);
    n_need   = CNTW'(1) + CNTW'(need0) + CNTW'(need1);
    room     = fl_avail[in_cluster] >= n_need;
    dst_idx  = t_pick[0];
    cp0_idx  = t_pick[1];
    cp1_idx  = need0 ? t_pick[2] : t_pick[1];
    take_vec = {need0 && need1, need0 || need1, 1'b1};
    h0       = first_holder(a_pres);
    h1       = first_holder(b_pres);
    s0_tag   = need0 ? {in_cluster, cp0_idx} : {in_cluster, a_idx[in_cluster]};
    if (b_pres[in_cluster])    s1_tag = {in_cluster, b_idx[in_cluster]};
    else if (in_src1 == in_src0) s1_tag = {in_cluster, cp0_idx};
    else                       s1_tag = {in_cluster, cp1_idx};
    old_mask = d_pres;
    for (int c = 0; c < NUM_CLUSTERS; c++)
      old_idx[c*IDXW +: IDXW] = d_idx[c];
    if (need0 && in_src0 == in_dst) begin
      old_mask = old_mask | tgt_bit;
      old_idx[in_cluster*IDXW +: IDXW] = cp0_idx;
    end
    if (need1 && in_src1 == in_dst) begin
      old_mask = old_mask | tgt_bit;
      old_idx[in_cluster*IDXW +: IDXW] = cp1_idx;
    end
  end

  assign in_ready = (!out_valid || out_ready) && room;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_src0_tag  <= '0;
      out_src1_tag  <= '0;
      out_dst_tag   <= '0;
      out_old_mask  <= '0;
      out_old_idx   <= '0;
      out_cp0_valid <= 1'b0;
      out_cp0_from  <= '0;
      out_cp0_to    <= '0;
      out_cp1_valid <= 1'b0;
      out_cp1_from  <= '0;
      out_cp1_to    <= '0;
    end else if (accept) begin
      out_valid     <= 1'b1;
      out_src0_tag  <= s0_tag;
      out_src1_tag  <= s1_tag;
      out_dst_tag   <= {in_cluster, dst_idx};
      out_old_mask  <= old_mask;
      out_old_idx   <= old_idx;
      out_cp0_valid <= need0;
      out_cp0_from  <= {h0, a_idx[h0]};
      out_cp0_to    <= {in_cluster, cp0_idx};
      out_cp1_valid <= need1;
      out_cp1_from  <= {h1, b_idx[h1]};
      out_cp1_to    <= {in_cluster, cp1_idx};
    end else if (out_ready) begin
      out_valid     <= 1'b0;
    end
  end
endmodule

// File: rtl/crn_rename_chk.sv
module crn_rename_chk import crn_pkg::*; (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_ready,
  input logic                          out_valid,
  input logic                          out_ready,
  input logic [TAGW-1:0]               out_src0_tag,
  input logic [TAGW-1:0]               out_src1_tag,
  input logic [TAGW-1:0]               out_dst_tag,
  input logic [NUM_CLUSTERS-1:0]       out_old_mask,
  input logic                          out_cp0_valid,
  input logic [TAGW-1:0]               out_cp0_from,
  input logic [TAGW-1:0]               out_cp0_to,
  input logic                          out_cp1_valid,
  input logic [TAGW-1:0]               out_cp1_from,
  input logic [TAGW-1:0]               out_cp1_to
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_dst_tag)
      && $stable(out_src0_tag) && $stable(out_src1_tag) && $stable(out_old_mask));

  p_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_src_cluster_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_src0_tag[TAGW-1 -: CLW] == out_dst_tag[TAGW-1 -: CLW]
      && out_src1_tag[TAGW-1 -: CLW] == out_dst_tag[TAGW-1 -: CLW]);

  p_copy_remote_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cp0_valid |-> out_cp0_from[TAGW-1 -: CLW] != out_cp0_to[TAGW-1 -: CLW]
      && out_cp0_to == out_src0_tag && out_cp0_to != out_dst_tag);

  p_copy_share_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cp1_valid |-> out_cp1_to == out_src1_tag
      && out_cp1_from[TAGW-1 -: CLW] != out_cp1_to[TAGW-1 -: CLW]);

  p_two_copies_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cp0_valid && out_cp1_valid |-> out_cp0_to != out_cp1_to
      && out_cp1_to != out_dst_tag);

  p_old_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_old_mask != '0);
endmodule

bind crn_rename crn_rename_chk u_chk (.*);

// File: tb/crn_rename_bench.sv
module crn_rename_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        in_valid = 0, in_ready, out_valid, out_ready = 0;
  logic [1:0]  in_cluster = 0;
  logic [3:0]  in_src0 = 0, in_src1 = 0, in_dst = 0;
  logic [6:0]  out_src0_tag, out_src1_tag, out_dst_tag;
  logic [3:0]  out_old_mask;
  logic [19:0] out_old_idx;
  logic        out_cp0_valid, out_cp1_valid;
  logic [6:0]  out_cp0_from, out_cp0_to, out_cp1_from, out_cp1_to;
  logic        commit_valid = 0;
  logic [3:0]  commit_mask = 0;
  logic [19:0] commit_idx = 0;

  crn_rename u_crn_rename (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  bit mp[16][4];
  int mi[16][4];
  bit mf[4][32];
  bit ov, o_c0v, o_c1v;
  int o_s0, o_s1, o_d, o_c0f, o_c0t, o_c1f, o_c1t;
  bit [3:0] o_mask;
  int o_oi[4];
  bit [3:0]  cq_mask[$];
  bit [19:0] cq_idx[$];

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int take(int cl);
    for (int i = 0; i < 32; i++)
      if (mf[cl][i]) begin mf[cl][i] = 0; return i; end
    return -1;
  endfunction

  function automatic int holder(int l);
    for (int c = 0; c < 4; c++) if (mp[l][c]) return c;
    return 0;
  endfunction

  task automatic step(bit v, int cl, int s0, int s1, int d, bit ordy, bit cmt_ok, int hand);
    bit need0, need1, rdy;
    int need, avail, dix, c0, c1, h0, h1;
    @(negedge clk);
    in_valid = v; in_cluster = 2'(cl); in_src0 = 4'(s0); in_src1 = 4'(s1); in_dst = 4'(d);
    out_ready = ordy;
    if (cmt_ok && cq_mask.size() > 0) begin
      commit_valid = 1; commit_mask = cq_mask.pop_front(); commit_idx = cq_idx.pop_front();
    end else begin
      commit_valid = 0; commit_mask = 0; commit_idx = 0;
    end
    #1;
    need0 = !mp[s0][cl];
    need1 = !mp[s1][cl] && (s0 != s1);
    need = 1 + int'(need0) + int'(need1);
    avail = 0;
    for (int i = 0; i < 32; i++) avail += int'(mf[cl][i]);
    rdy = (!ov || ordy) && (avail >= need);
    chk("R8", "in_ready", int'(in_ready), int'(rdy));
    chk("R9", "out_valid", int'(out_valid), int'(ov));
    if (ov) begin
      chk("R2/R7", "dst_tag", int'(out_dst_tag), o_d);
      chk("R3/R4", "src0_tag", int'(out_src0_tag), o_s0);
      chk("R3/R5", "src1_tag", int'(out_src1_tag), o_s1);
      chk("R4", "cp0_valid", int'(out_cp0_valid), int'(o_c0v));
      if (o_c0v) begin
        chk("R4", "cp0_from", int'(out_cp0_from), o_c0f);
        chk("R4", "cp0_to", int'(out_cp0_to), o_c0t);
      end
      chk("R5", "cp1_valid", int'(out_cp1_valid), int'(o_c1v));
      if (o_c1v) begin
        chk("R10", "cp1_from", int'(out_cp1_from), o_c1f);
        chk("R10", "cp1_to", int'(out_cp1_to), o_c1t);
      end
      chk("R6", "old_mask", int'(out_old_mask), int'(o_mask));
      for (int c = 0; c < 4; c++)
        if (o_mask[c]) chk("R6", "old_idx", int'(out_old_idx[c*5 +: 5]), o_oi[c]);
    end
    if (hand == 1) begin
      chk("R1", "reset out_valid", int'(out_valid), 0);
      chk("R1", "reset in_ready", int'(in_ready), 1);
    end
    if (hand == 2) begin
      chk("R2", "hand dst", int'(out_dst_tag), 32);
      chk("R5", "hand shared src", int'(out_src1_tag), 33);
      chk("R5", "hand single copy", int'(out_cp1_valid), 0);
      chk("R4", "hand copy from", int'(out_cp0_from), 2);
      chk("R6", "hand old mask", int'(out_old_mask), 3);
      chk("R6", "hand old copy idx", int'(out_old_idx[9:5]), 1);
    end
    if (hand == 3) begin
      chk("R10", "hand cp0 from", int'(out_cp0_from), 32);
      chk("R10", "hand cp1 from", int'(out_cp1_from), 5);
      chk("R10", "hand cp1 to", int'(out_cp1_to), 98);
      chk("R2", "hand dst", int'(out_dst_tag), 96);
    end
    // model of the clock edge
    if (ov && ordy) begin
      bit [19:0] pk;
      pk = '0;
      for (int c = 0; c < 4; c++) pk[c*5 +: 5] = 5'(o_oi[c]);
      cq_mask.push_back(o_mask);
      cq_idx.push_back(pk);
    end
    if (v && rdy) begin
      dix = take(cl);
      c0 = need0 ? take(cl) : 0;
      c1 = need1 ? take(cl) : 0;
      h0 = holder(s0); h1 = holder(s1);
      o_s0 = need0 ? cl*32 + c0 : cl*32 + mi[s0][cl];
      if (mp[s1][cl]) o_s1 = cl*32 + mi[s1][cl];
      else if (s1 == s0) o_s1 = cl*32 + c0;
      else o_s1 = cl*32 + c1;
      o_c0v = need0; o_c0f = h0*32 + mi[s0][h0]; o_c0t = cl*32 + c0;
      o_c1v = need1; o_c1f = h1*32 + mi[s1][h1]; o_c1t = cl*32 + c1;
      if (need0) begin mp[s0][cl] = 1; mi[s0][cl] = c0; end
      if (need1) begin mp[s1][cl] = 1; mi[s1][cl] = c1; end
      for (int c = 0; c < 4; c++) begin
        o_mask[c] = mp[d][c];
        o_oi[c] = mi[d][c];
        mp[d][c] = 0;
      end
      mp[d][cl] = 1; mi[d][cl] = dix;
      o_d = cl*32 + dix;
      ov = 1;
    end else if (ov && ordy) begin
      ov = 0;
    end
    if (commit_valid)
      for (int c = 0; c < 4; c++)
        if (commit_mask[c]) mf[c][commit_idx[c*5 +: 5]] = 1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < 16; l++)
      for (int c = 0; c < 4; c++) begin mp[l][c] = (c == 0); mi[l][c] = (c == 0) ? l : 0; end
    for (int c = 0; c < 4; c++)
      for (int i = 0; i < 32; i++) mf[c][i] = (c != 0) || (i >= 16);
    ov = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 1, 0, 1);      // R1 reset state
    step(1, 1, 2, 2, 2, 1, 0, 0);      // same remote source, src equals dst
    step(1, 3, 2, 5, 7, 1, 0, 2);      // two copies from different clusters
    step(0, 0, 0, 0, 0, 1, 0, 3);
    for (int i = 0; i < 2600; i++) begin
      bit v, ordy, cm;
      v    = ($urandom_range(0, 9) < 8);
      ordy = ($urandom_range(0, 3) != 0);
      cm   = (i < 500) ? ($urandom_range(0, 9) == 0) : ($urandom_range(0, 9) < 7);
      step(v, $urandom_range(0, 3), $urandom_range(0, 15), $urandom_range(0, 15),
           $urandom_range(0, 15), ordy, cm, 0);
    end
    done = 1;
    summary();
    $finish;
  end
endmodule